// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Boot Station-Address Fetch

This block is a master for a three-wire serial EEPROM with 6-bit word addressing. It reads 16-bit words and never writes. The block drives the chip select, the serial clock and the serial data line into the memory. It samples the data line coming back from the memory.

Each access is built from fixed-length clock phases, and each phase lasts `PHASE_CLKS` system clocks. An access has these steps, in order:
1. Chip select goes low, then rises again.
2. An 11-bit read command is shifted out most significant bit first.
3. One turnaround phase follows.
4. Sixteen data bits are clocked in, most significant bit first.
5. Chip select is released.

After reset, the block reads words 0 to 15 into an internal buffer without any help from the host. From that buffer it assembles a 48-bit station address out of bytes 20 to 25. Each word holds its lower-numbered byte in bits 7:0. Once this boot walk ends, the host can issue single-word reads through a valid/ready request port. Each result comes back as a one-cycle response pulse.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ee_cs`, `ee_sk`, `rsp_valid`, `req_ready` and `boot_done` are all low.
- R2: The command is 11 bits sent MSB first: `0,0,1,1,0` and then the six address bits, MSB first. `ee_di` changes only while `ee_sk` is low, and it holds its value through each high phase.
- R3: Before the first command clock, `ee_cs` stays low for one phase and then rises. `ee_sk` is high only while `ee_cs` is high. An access contains exactly 27 rising edges of `ee_sk`. `ee_cs` is low again by the cycle in which the result is presented.
- R4: After the command there is one phase with the clock low. Then 16 data bits are taken from `ee_do`, MSB first. Each bit is sampled in the last system clock of an `ee_sk` high phase.
- R5: Every `ee_sk` high phase lasts `PHASE_CLKS` (default 4) system clocks. A request taken at clock edge k produces `rsp_valid` after edge k+58·`PHASE_CLKS`. `req_ready` is low from edge k until that same edge.
- R6: A request is taken only on an edge where both `req_valid` and `req_ready` are high. `req_valid` or a changing `req_addr` while `req_ready` is low has no effect on the access in progress, and no later access comes from it.
- R7: `rsp_valid` is high for exactly one cycle, and `rsp_data` is valid in that cycle. The response has no back-pressure. `req_ready` is already high in the response cycle, so a held request is taken on the next edge.
- R8: After reset, words 0 to 15 are read in ascending address order. No `rsp_valid` pulse is produced for them, and `req_ready` stays low until `boot_done` is high.
- R9: `station_addr[47:40]` holds byte 20, and the lower fields follow in order down to byte 25 in `station_addr[7:0]`. Byte 2n is bits 7:0 of word n, and byte 2n+1 is bits 15:8.
- R10: Once `boot_done` rises, it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_addr | input | 6 | Word address of the request |
| req_ready | output | 1 | High when a request can be taken |
| rsp_valid | output | 1 | One-cycle pulse marking the result |
| rsp_data | output | 16 | Word read from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |
| boot_done | output | 1 | Boot walk over, station address valid |
| station_addr | output | 48 | Station address from bytes 20 to 25 |

## Verification
The hardest case to reach is a request that arrives while an access is running or just as one ends. That includes a held `req_valid` whose address changes mid-access, and a request that meets the response cycle.

The stimulus covers both cases:
- It keeps `req_valid` high across a whole access while changing `req_addr`.
- It keeps `req_valid` high across two accesses, so that the second request is taken on the edge right after the response.

A behavioural EEPROM model logs every address it decodes, so any request wrongly taken shows up as an extra access.

// File: rtl/mw_pkg.sv
package mw_pkg;

  // Serial access phases, in the order they occur
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_CSOFF,
    PH_CSON,
    PH_CLO,
    PH_CHI,
    PH_TURN,
    PH_DHI,
    PH_DLO,
    PH_END
  } mw_phase_e;

  // Start bit plus read opcode
  localparam logic [2:0] READ_OP = 3'b110;

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int PHASE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;

  logic [CW-1:0] cnt_q;

  assign last = run && (cnt_q == CW'(PHASE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || last)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mw_serial_engine.sv
module mw_serial_engine
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int PHASE_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cs,
  output logic              sk,
  output logic              di,
  input  logic              dout_in
);
  localparam int CMD_W   = ADDR_W + 5;
  localparam int CNT_MAX = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int BIT_W   = $clog2(CNT_MAX);

  mw_phase_e         st_q, st_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] sh_q;
  logic              tick;
  logic              done_q, cs_q, sk_q, di_q;

  mw_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q != PH_IDLE),
    .last (tick)
  );

  always_comb begin
    st_d  = st_q;
    bit_d = bit_q;
    case (st_q)
      PH_IDLE:  if (go) st_d = PH_CSOFF;
      PH_CSOFF: if (tick) st_d = PH_CSON;
      PH_CSON:  if (tick) begin
                  st_d  = PH_CLO;
                  bit_d = BIT_W'(CMD_W - 1);
                end
      PH_CLO:   if (tick) st_d = PH_CHI;
      PH_CHI:   if (tick) begin
                  if (bit_q == '0) st_d = PH_TURN;
                  else begin
                    st_d  = PH_CLO;
                    bit_d = bit_q - 1'b1;
                  end
                end
      PH_TURN:  if (tick) begin
                  st_d  = PH_DHI;
                  bit_d = BIT_W'(DATA_W - 1);
                end
      PH_DHI:   if (tick) st_d = PH_DLO;
      PH_DLO:   if (tick) begin
                  if (bit_q == '0) st_d = PH_END;
                  else begin
                    st_d  = PH_DHI;
                    bit_d = bit_q - 1'b1;
                  end
                end
      PH_END:   if (tick) st_d = PH_IDLE;
      default:  st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      bit_q  <= '0;
      cmd_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      cs_q   <= 1'b0;
      sk_q   <= 1'b0;
      di_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      if (st_q == PH_IDLE && go) cmd_q <= {2'b00, READ_OP, addr};
      // sample in the last clock of a high phase
      if (st_q == PH_DHI && tick) sh_q <= {sh_q[DATA_W-2:0], dout_in};
      done_q <= (st_q == PH_END) && tick;
      // pins come from the next phase so they toggle as clean flop outputs
      cs_q   <= (st_d != PH_IDLE) && (st_d != PH_CSOFF) && (st_d != PH_END);
      sk_q   <= (st_d == PH_CHI) || (st_d == PH_DHI);
      di_q   <= ((st_d == PH_CLO) || (st_d == PH_CHI)) ? cmd_q[bit_d] : 1'b0;
    end
  end

  assign idle  = (st_q == PH_IDLE);
  assign done  = done_q;
  assign rdata = sh_q;
  assign cs    = cs_q;
  assign sk    = sk_q;
  assign di    = di_q;
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int WORDS     = 16,
  parameter int DATA_W    = 16,
  parameter int MAC_OFS   = 20,
  parameter int MAC_BYTES = 6,
  parameter int IDX_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [MAC_BYTES*8-1:0] station_addr
);
  localparam int BPW = DATA_W / 8;

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  // lower byte address sits in the low bits of each word; first byte goes to the top field
  for (genvar b = 0; b < MAC_BYTES; b++) begin : g_mac
    localparam int BYTE_N = MAC_OFS + b;
    localparam int WI     = BYTE_N / BPW;
    localparam int LANE   = BYTE_N % BPW;
    assign station_addr[(MAC_BYTES-1-b)*8 +: 8] = mem_q[WI][LANE*8 +: 8];
  end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int PHASE_CLKS = 4,
  parameter int BOOT_WORDS = 16,
  parameter int MAC_OFS    = 20,
  parameter int MAC_BYTES  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic                   ee_cs,
  output logic                   ee_sk,
  output logic                   ee_di,
  input  logic                   ee_do,
  output logic                   boot_done,
  output logic [MAC_BYTES*8-1:0] station_addr
);
  localparam int IDX_W = $clog2(BOOT_WORDS);

  logic              boot_q;
  logic [IDX_W-1:0]  idx_q;
  logic              eng_go, eng_idle, eng_done;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_rdata;
  logic              go_boot, go_host;

  // one idle cycle after each boot word keeps the index update off the launch path
  assign go_boot   = boot_q && eng_idle && !eng_done;
  assign req_ready = !boot_q && eng_idle;
  assign go_host   = req_valid && req_ready;
  assign eng_go    = go_boot || go_host;
  assign eng_addr  = boot_q ? ADDR_W'(idx_q) : req_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      idx_q  <= '0;
    end else if (boot_q && eng_done) begin
      if (idx_q == IDX_W'(BOOT_WORDS - 1)) boot_q <= 1'b0;
      else                                 idx_q  <= idx_q + 1'b1;
    end
  end

  mw_serial_engine #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PHASE_CLKS(PHASE_CLKS)
  ) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (eng_go),
    .addr   (eng_addr),
    .idle   (eng_idle),
    .done   (eng_done),
    .rdata  (eng_rdata),
    .cs     (ee_cs),
    .sk     (ee_sk),
    .di     (ee_di),
    .dout_in(ee_do)
  );

  mw_word_store #(
    .WORDS    (BOOT_WORDS),
    .DATA_W   (DATA_W),
    .MAC_OFS  (MAC_OFS),
    .MAC_BYTES(MAC_BYTES),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (boot_q && eng_done),
    .wr_idx      (idx_q),
    .wr_data     (eng_rdata),
    .station_addr(station_addr)
  );

  assign rsp_valid = eng_done && !boot_q;
  assign rsp_data  = eng_rdata;
  assign boot_done = !boot_q;
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic boot_done
);
  assert_sk_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  assert_di_held_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  assert_di_held_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> $stable(ee_di));

  assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_cs_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !ee_cs);

  assert_take_drops_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_boot_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);

  assert_quiet_in_boot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> (!req_ready && !rsp_valid));
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .ee_cs    (ee_cs),
  .ee_sk    (ee_sk),
  .ee_di    (ee_di),
  .boot_done(boot_done)
);

// File: tb/sim_mw_eeprom_reader.sv
module sim_mw_eeprom_reader;
  localparam int PH       = 4;
  localparam int WORD_CYC = 58 * PH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_addr = '0;
  logic        req_ready, rsp_valid, ee_cs, ee_sk, ee_di, boot_done;
  logic        ee_do = 1'b0;
  logic [15:0] rsp_data;
  logic [47:0] station_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 20 ns period

  mw_eeprom_reader #(.PHASE_CLKS(PH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .boot_done(boot_done), .station_addr(station_addr)
  );

  function automatic logic [15:0] rom(input int a);
    return 16'((a * 13579 + 2468) ^ (a << 9));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM ----------------
  int          sk_rise = 0;
  logic [10:0] cmd_sr = '0;
  logic [15:0] out_word = '0;
  int          addr_log[$];

  always @(posedge ee_cs) if (rst_n) begin
    sk_rise = 0;
    cmd_sr  = '0;
  end

  always @(posedge ee_sk) if (rst_n && ee_cs === 1'b1) begin
    if (sk_rise < 11) begin
      cmd_sr = {cmd_sr[9:0], ee_di};
      if (sk_rise == 10) begin
        chk(cmd_sr[10:6] == 5'b00110, "R2 command prefix", cmd_sr[10:6], 5'b00110);
        addr_log.push_back(int'(cmd_sr[5:0]));
        out_word = rom(int'(cmd_sr[5:0]));
        ee_do = 1'b0;
      end
    end else if (sk_rise <= 26) begin
      ee_do = out_word[26 - sk_rise];
    end
    sk_rise++;
  end

  always @(negedge ee_cs) if (rst_n) begin
    chk(sk_rise == 27, "R3 clock count per access", sk_rise, 27);
  end

  // ---------------- clock width ----------------
  int hi_run = 0;
  always @(negedge clk) if (rst_n) begin
    if (ee_sk === 1'b1) hi_run++;
    else begin
      if (hi_run != 0) chk(hi_run == PH, "R5 sk high width", hi_run, PH);
      hi_run = 0;
    end
  end

  // ---------------- reference model ----------------
  bit          live = 0;
  bit          booting = 0;
  int          left = 0;
  logic        exp_rsp = 1'b0;
  logic [15:0] exp_data = '0;
  int          exp_addrs[$];

  always @(posedge clk) if (live) begin
    exp_rsp = 1'b0;
    if (left > 0) begin
      left--;
      if (left == 0) exp_rsp = 1'b1;
    end else if (req_valid) begin
      left = WORD_CYC;
      exp_addrs.push_back(int'(req_addr));
      exp_data = rom(int'(req_addr));
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(req_ready === (left == 0), "R5 req_ready", req_ready, (left == 0));
      chk(rsp_valid === exp_rsp, "R7 rsp_valid", rsp_valid, exp_rsp);
      if (exp_rsp) chk(rsp_data === exp_data, "R4 rsp_data", rsp_data, exp_data);
      chk(boot_done === 1'b1, "R10 boot_done held", boot_done, 1);
    end else if (booting) begin
      chk(rsp_valid === 1'b0, "R8 no response during boot", rsp_valid, 0);
    end
  end

  task automatic do_req(input logic [5:0] a);
    @(negedge clk);
    while (req_ready !== 1'b1) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (WORD_CYC + 6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [47:0] mac_exp;
    int n0;
    repeat (3) @(negedge clk);
    chk(ee_cs === 1'b0, "R1 cs in reset", ee_cs, 0);
    chk(ee_sk === 1'b0, "R1 sk in reset", ee_sk, 0);
    chk(req_ready === 1'b0, "R1 ready in reset", req_ready, 0);
    chk(boot_done === 1'b0, "R1 boot_done in reset", boot_done, 0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b0 && boot_done === 1'b0, "R1 state after release", {req_ready, boot_done}, 0);
    booting = 1;
    while (boot_done !== 1'b1) @(negedge clk);
    booting = 0;
    live = 1;

    // R8: boot walk order
    chk(addr_log.size() == 16, "R8 boot word count", addr_log.size(), 16);
    for (int i = 0; i < 16 && i < addr_log.size(); i++)
      chk(addr_log[i] == i, "R8 boot address order", addr_log[i], i);
    chk(req_ready === 1'b1, "R8 ready after boot", req_ready, 1);

    // R9: station address byte order
    for (int b = 0; b < 6; b++) begin
      logic [15:0] w;
      w = rom((20 + b) / 2);
      mac_exp[(5 - b) * 8 +: 8] = ((20 + b) % 2) ? w[15:8] : w[7:0];
    end
    chk(station_addr === mac_exp, "R9 station_addr", station_addr, mac_exp);
    addr_log.delete();

    // single reads at boundaries and mixed patterns (R2, R4)
    do_req(6'd0);
    do_req(6'd63);
    do_req(6'd42);
    do_req(6'd21);
    settle();

    // R6: held valid with changing address while busy
    n0 = addr_log.size();
    @(negedge clk);
    while (req_ready !== 1'b1) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 6'd9;
    @(negedge clk);
    req_addr  = 6'd50;
    repeat (100) @(negedge clk);
    req_valid = 1'b0;
    settle();
    chk(addr_log.size() == n0 + 1, "R6 only one access taken", addr_log.size(), n0 + 1);
    if (addr_log.size() > n0) chk(addr_log[n0] == 9, "R6 address latched at take", addr_log[n0], 9);

    // R7: back-to-back with held valid
    @(negedge clk);
    while (req_ready !== 1'b1) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 6'd33;
    @(negedge clk);
    req_addr  = 6'd34;
    repeat (300) @(negedge clk);
    req_valid = 1'b0;
    settle();

    // R2: every access addressed as requested
    chk(addr_log.size() == exp_addrs.size(), "R2 access count", addr_log.size(), exp_addrs.size());
    for (int i = 0; i < addr_log.size() && i < exp_addrs.size(); i++)
      chk(addr_log[i] == exp_addrs[i], "R2 address sent", addr_log[i], exp_addrs[i]);
    finish_run();
  end
endmodule